// File: doc/BRIEF.md
# Subtract Instruction Execute Unit

This unit carries out the two subtract instructions of a small accumulator-style controller. In both, the working register W is the subtrahend. The literal form subtracts W from an 8-bit constant held in the instruction and puts the result in W. The register form subtracts W from a byte in data memory and puts the result either in W or back into that byte. Both forms update five status flags: negative, overflow, zero, digit carry and carry. Carry and digit carry work as inverted borrows.

An instruction is accepted with `start_i` while the unit is idle. The unit captures the instruction word, the current W and the bank-select value. It then runs four phases of one clock each: decode, operand read, process, and write. The read strobe to the external register file is active only in the read phase. All result strobes are active only in the write phase. A word that matches neither encoding changes nothing and raises `illegal_o` in the write phase.

Top module: `sub_exec_unit`

## Requirements
- R1: A word whose upper byte is 08h is the literal form. It computes k − W, with k = bits [7:0]. The result goes out on `w_o` with `w_we_o` high, `wr_en_o` stays low, and the register file is never read (`rd_en_o` stays low).
- R2: A word whose bits [15:10] are 010111b is the register form. It computes mem[addr] − W, using the byte returned on `rd_data_i` during the read phase.
- R3: In the register form, bit 9 picks the destination. A 0 gives `w_we_o` high with the register file untouched. A 1 gives `wr_en_o` high, with the result written to the same address that was read and W left unwritten.
- R4: In the register form with bit 8 = 1, the 12-bit data address is {bank-select[3:0], bits [7:0]}.
- R5: In the register form with bit 8 = 0, the bank-select value is ignored. Offsets 00h–5Fh address bank 0 and offsets 60h–FFh address bank Fh.
- R6: `flags_o` is {N, OV, Z, DC, C} from bit 4 down to bit 0. C = 1 when the minuend ≥ W (no borrow). Z = 1 when the result is 00h.
- R7: DC = 1 when the low nibble of the minuend ≥ the low nibble of W, that is, no borrow out of bit 3.
- R8: N equals bit 7 of the result. OV = 1 when the true signed difference lies outside −128..127.
- R9: After `start_i` is accepted, `busy_o` is high for four cycles. The read strobe appears in the second of these cycles and all write strobes appear in the fourth. `start_i` is ignored while the unit is busy.
- R10: Any other word leaves W, the flags and the register file unwritten, and raises `illegal_o` for exactly the write-phase cycle.
- R11: While reset is asserted, `busy_o`, `rd_en_o`, `wr_en_o`, `w_we_o`, `flags_we_o` and `illegal_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept `instr_i` (only when idle) |
| instr_i | input | 16 | Instruction word |
| w_i | input | 8 | Current W value |
| bank_i | input | 4 | Current bank-select value |
| busy_o | output | 1 | An instruction is in flight |
| rd_en_o | output | 1 | Register-file read strobe |
| rd_addr_o | output | 12 | Register-file read address |
| rd_data_i | input | 8 | Register-file read data, same cycle |
| wr_en_o | output | 1 | Register-file write strobe |
| wr_addr_o | output | 12 | Register-file write address |
| wr_data_o | output | 8 | Register-file write data |
| w_we_o | output | 1 | Load W from `w_o` |
| w_o | output | 8 | New W value |
| flags_we_o | output | 1 | Load status from `flags_o` |
| flags_o | output | 5 | {N, OV, Z, DC, C} |
| illegal_o | output | 1 | Unrecognised opcode, one cycle |

## Verification
The assertions check the timing and structure rules on every cycle:
- the phase order, and that no restart happens mid-instruction;
- that the read strobe appears only in the read phase and all writes only in the write phase;
- that no more than one destination is written;
- that an illegal word writes nothing;
- that any written result plus W gives back the captured operand;
- that a zero result never comes with a borrow.

Only the bench scenarios can show the rest. This covers the address decoding on both sides of the 60h access split and with several bank values, and the destination steering by bit 9. It also covers the exact DC, OV and N values at nibble and sign boundaries, and that the register file keeps its contents when W is the destination.

// File: rtl/sub_exec_pkg.sv
package sub_exec_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_DEC, PH_READ, PH_PROC, PH_WRITE} phase_e;
  typedef enum logic [1:0] {OP_NONE, OP_LIT, OP_REG} op_kind_e;
  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic dc;
    logic c;
  } flags_t;
  localparam logic [7:0] LIT_OPC = 8'h08;
  localparam logic [5:0] REG_OPC = 6'b010111;
endpackage

// File: rtl/sub_seq.sv
module sub_seq
  import sub_exec_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output phase_e phase_o
);
  phase_e phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else begin
      unique case (phase_q)
        PH_IDLE:  if (start_i) phase_q <= PH_DEC;
        PH_DEC:   phase_q <= PH_READ;
        PH_READ:  phase_q <= PH_PROC;
        PH_PROC:  phase_q <= PH_WRITE;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;

  a_r9_phase_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DEC) |=> (phase_q == PH_READ));
  a_r9_write_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WRITE) |=> (phase_q == PH_IDLE));
  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && phase_q != PH_WRITE) |=> (phase_q != PH_DEC));
endmodule

// File: rtl/sub_decode.sv
module sub_decode
  import sub_exec_pkg::*;
#(
  parameter int unsigned DW           = 8,
  parameter int unsigned BW           = 4,
  parameter int unsigned ACCESS_SPLIT = 8'h60,
  localparam int unsigned AW          = BW + DW
) (
  input  logic [15:0]   instr_i,
  input  logic [BW-1:0] bank_i,
  output op_kind_e      kind_o,
  output logic          to_file_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] lit_o
);
  logic          use_bank;
  logic [DW-1:0] offs;
  logic [BW-1:0] bank_sel;

  assign use_bank  = instr_i[8];
  assign offs      = instr_i[DW-1:0];
  assign lit_o     = instr_i[DW-1:0];
  assign to_file_o = instr_i[9];

  always_comb begin
    if (instr_i[15:8] == LIT_OPC)       kind_o = OP_LIT;
    else if (instr_i[15:10] == REG_OPC) kind_o = OP_REG;
    else                                kind_o = OP_NONE;
  end

  // access bank: low offsets in bank 0, high offsets in the top bank
  always_comb begin
    if (use_bank)                          bank_sel = bank_i;
    else if (32'(offs) < ACCESS_SPLIT)     bank_sel = '0;
    else                                   bank_sel = '1;
  end

  assign addr_o = {bank_sel, offs};
endmodule

// File: rtl/sub_alu.sv
module sub_alu
  import sub_exec_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned HW = DW / 2
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] diff_o,
  output flags_t        flags_o
);
  logic          borrow;
  logic          half_borrow;
  logic [HW-1:0] half_diff;

  assign {borrow, diff_o}         = {1'b0, a_i} - {1'b0, b_i};
  assign {half_borrow, half_diff} = {1'b0, a_i[HW-1:0]} - {1'b0, b_i[HW-1:0]};

  always_comb begin
    flags_o.c  = ~borrow;
    flags_o.dc = ~half_borrow;
    flags_o.z  = (diff_o == '0);
    flags_o.n  = diff_o[DW-1];
    flags_o.ov = (a_i[DW-1] ^ b_i[DW-1]) & (diff_o[DW-1] ^ a_i[DW-1]);
  end

  logic unused_half;
  assign unused_half = ^half_diff;
endmodule

// File: rtl/sub_exec_unit.sv
module sub_exec_unit
  import sub_exec_pkg::*;
#(
  parameter int unsigned DW           = 8,
  parameter int unsigned BW           = 4,
  parameter int unsigned ACCESS_SPLIT = 8'h60,
  localparam int unsigned AW          = BW + DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [15:0]   instr_i,
  input  logic [DW-1:0] w_i,
  input  logic [BW-1:0] bank_i,
  output logic          busy_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          w_we_o,
  output logic [DW-1:0] w_o,
  output logic          flags_we_o,
  output logic [4:0]    flags_o,
  output logic          illegal_o
);
  phase_e        phase;
  logic          accept;
  logic [15:0]   instr_q;
  logic [DW-1:0] w_q;
  logic [BW-1:0] bank_q;
  logic [DW-1:0] operand_q;
  logic [DW-1:0] result_q;
  flags_t        flags_q;

  op_kind_e      kind;
  logic          to_file;
  logic [AW-1:0] addr;
  logic [DW-1:0] lit;
  logic [DW-1:0] diff;
  flags_t        alu_flags;

  sub_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .phase_o (phase)
  );

  sub_decode #(.DW(DW), .BW(BW), .ACCESS_SPLIT(ACCESS_SPLIT)) u_dec (
    .instr_i   (instr_q),
    .bank_i    (bank_q),
    .kind_o    (kind),
    .to_file_o (to_file),
    .addr_o    (addr),
    .lit_o     (lit)
  );

  sub_alu #(.DW(DW)) u_alu (
    .a_i     (operand_q),
    .b_i     (w_q),
    .diff_o  (diff),
    .flags_o (alu_flags)
  );

  assign accept = start_i && (phase == PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_q   <= '0;
      w_q       <= '0;
      bank_q    <= '0;
      operand_q <= '0;
      result_q  <= '0;
      flags_q   <= '0;
    end else begin
      if (accept) begin
        instr_q <= instr_i;
        w_q     <= w_i;
        bank_q  <= bank_i;
      end
      if (phase == PH_READ) operand_q <= (kind == OP_REG) ? rd_data_i : lit;
      if (phase == PH_PROC) begin
        result_q <= diff;
        flags_q  <= alu_flags;
      end
    end
  end

  logic in_write;
  assign in_write   = (phase == PH_WRITE);
  assign busy_o     = (phase != PH_IDLE);
  assign rd_en_o    = (phase == PH_READ) && (kind == OP_REG);
  assign rd_addr_o  = addr;
  assign wr_en_o    = in_write && (kind == OP_REG) && to_file;
  assign wr_addr_o  = addr;
  assign wr_data_o  = result_q;
  assign w_we_o     = in_write && ((kind == OP_LIT) || ((kind == OP_REG) && !to_file));
  assign w_o        = result_q;
  assign flags_we_o = in_write && (kind != OP_NONE);
  assign flags_o    = flags_q;
  assign illegal_o  = in_write && (kind == OP_NONE);

  a_r9_read_phase_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (phase == PH_READ));
  a_r9_write_phase_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o || w_we_o || flags_we_o || illegal_o) |-> (phase == PH_WRITE));
  a_r3_single_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_en_o, w_we_o}));
  a_r10_illegal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !(wr_en_o || w_we_o || flags_we_o));
  a_r2_diff_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o || w_we_o) |-> (DW'(wr_data_o + w_q) == operand_q));
  a_r6_zero_no_borrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_we_o && flags_o[2]) |-> flags_o[0]);
endmodule

// File: tb/sub_exec_unit_test.sv
module sub_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [7:0]  w_reg = '0;
  logic [3:0]  bank = '0;
  logic        busy, rd_en, wr_en, w_we, flags_we, illegal;
  logic [11:0] rd_addr, wr_addr;
  logic [7:0]  rd_data, wr_data, w_out;
  logic [4:0]  flags;
  logic [7:0]  mem [4096];

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sub_exec_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr), .w_i(w_reg),
    .bank_i(bank), .busy_o(busy), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .w_we_o(w_we), .w_o(w_out), .flags_we_o(flags_we), .flags_o(flags),
    .illegal_o(illegal)
  );

  assign rd_data = mem[rd_addr];
  always @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (w_we)  w_reg <= w_out;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] exp_sub(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    int sd;
    logic n, ov, z, dc, c;
    r  = a - b;
    sd = int'($signed(a)) - int'($signed(b));
    c  = (a >= b);
    dc = (a[3:0] >= b[3:0]);
    z  = (r == 8'h00);
    n  = r[7];
    ov = (sd > 127) || (sd < -128);
    return {r, n, ov, z, dc, c};
  endfunction

  // kind: 0 none, 1 literal, 2 register
  task automatic run(input logic [15:0] ins, input logic [3:0] bk, input string req);
    int kind;
    logic [11:0] addr;
    logic [7:0] opnd, w0, keep;
    logic [12:0] e;
    if (ins[15:8] == 8'h08)         kind = 1;
    else if (ins[15:10] == 6'b010111) kind = 2;
    else                            kind = 0;
    if (ins[8])                addr = {bk, ins[7:0]};
    else if (ins[7:0] < 8'h60) addr = {4'h0, ins[7:0]};
    else                       addr = {4'hF, ins[7:0]};
    w0   = w_reg;
    opnd = (kind == 2) ? mem[addr] : ins[7:0];
    keep = mem[addr];
    e    = exp_sub(opnd, w0);
    @(negedge clk);
    start = 1'b1; instr = ins; bank = bk;
    @(negedge clk);                       // decode phase
    start = 1'b0;
    check({req, " R9 busy"}, busy, 1);
    @(negedge clk);                       // read phase
    check({req, " R1 R2 rd_en"}, rd_en, kind == 2);
    if (kind == 2) check({req, " R4 R5 rd_addr"}, rd_addr, addr);
    @(negedge clk);                       // process phase
    check({req, " R9 no early write"}, {wr_en, w_we, flags_we}, 0);
    @(negedge clk);                       // write phase
    check({req, " R10 illegal"}, illegal, kind == 0);
    check({req, " R6 flags_we"}, flags_we, kind != 0);
    check({req, " R3 w_we"}, w_we, (kind == 1) || (kind == 2 && !ins[9]));
    check({req, " R3 wr_en"}, wr_en, kind == 2 && ins[9]);
    if (kind != 0) begin
      check({req, " R1 R2 result"}, w_out, e[12:5]);
      check({req, " R6 R7 R8 flags"}, flags, e[4:0]);
    end
    if (kind == 2 && ins[9]) check({req, " R3 wr_addr"}, wr_addr, addr);
    @(negedge clk);
    check({req, " R9 idle"}, busy, 0);
    if (kind != 2 || !ins[9]) check({req, " R3 R10 mem kept"}, mem[addr], keep);
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 37 + 5);
    void'($urandom(32'h1bad_5eed));
    #20;
    check("R11 reset busy", busy, 0);
    check("R11 reset strobes", {rd_en, wr_en, w_we, flags_we, illegal}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 literal: 2-1, 2-2, 2-3
    w_reg = 8'h01; run(16'h0802, 4'h3, "R1 lit pos");
    w_reg = 8'h02; run(16'h0802, 4'h3, "R1 lit zero");
    w_reg = 8'h03; run(16'h0802, 4'h3, "R1 lit neg");
    // R7 nibble borrow, R8 signed overflow
    w_reg = 8'h01; run(16'h0810, 4'h0, "R7 dc borrow");
    w_reg = 8'h01; run(16'h0880, 4'h0, "R8 ov neg-pos");
    w_reg = 8'h80; run(16'h0801, 4'h0, "R8 ov pos-neg");
    // R2/R3 register forms with known operands
    mem[12'h025] = 8'h03; w_reg = 8'h02; run(16'h5E25, 4'h7, "R3 d1 to file");
    mem[12'h025] = 8'h02; w_reg = 8'h02; run(16'h5C25, 4'h7, "R2 d0 to W");
    // R5 access split edges, bank ignored
    w_reg = 8'h11; run(16'h5E5F, 4'h9, "R5 offs 5F");
    w_reg = 8'h22; run(16'h5E60, 4'h9, "R5 offs 60");
    // R4 banked
    w_reg = 8'h33; run(16'h5FA4, 4'h6, "R4 bank 6");
    w_reg = 8'h44; run(16'h5D10, 4'hC, "R4 bank C");
    // R10 illegal
    w_reg = 8'h55; run(16'h0900, 4'h0, "R10 near lit");
    run(16'h5800, 4'h0, "R10 near reg");

    // R9: start while busy is ignored
    w_reg = 8'h05;
    @(negedge clk); start = 1'b1; instr = 16'h0807;
    @(negedge clk); start = 1'b1; instr = 16'hFFFF;
    @(negedge clk); @(negedge clk); start = 1'b0;
    @(negedge clk);
    check("R9 restart ignored illegal", illegal, 0);
    check("R9 restart ignored result", w_out, 8'h02);
    @(negedge clk);
    check("R9 restart ignored busy", busy, 0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [15:0] ins;
      int sel;
      sel = $urandom_range(0, 9);
      ins = 16'($urandom);
      if (sel < 4)      ins[15:8]  = 8'h08;
      else if (sel < 8) ins[15:10] = 6'b010111;
      w_reg = 8'($urandom);
      run(ins, 4'($urandom), "rand R1 R2 R3 R4 R5 R6 R7 R8 R10");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule